// File: doc/BRIEF.md
# Capability Derivation Unit

This unit computes the result of a single capability-deriving operation. A decode stage presents one source capability, two 64-bit integer operands, a 12-bit immediate, an operation code and a flag that says whether the source and destination register indices are equal. One clock later the unit returns three things. The first is the destination capability with a write enable. The second is the rewritten source capability with its own write enable, which carries the move-out behaviour of linear capabilities. The third is an integer result for field queries. A fault code comes back with them.

The supported operations are move, cursor increment by register or by immediate, cursor set, field query, bounds shrink, bounds split, permission tighten, delinearise, initialise, seal and make-revocation. A linear capability is never duplicated: an operation that derives a new capability from it nulls the original, unless both indices name the same register. Any faulting operation writes nothing. The register file, memory and the global revocation sweep live outside this unit.

Top module: `cap_derive_unit`

## Requirements
- R1: Results appear on the clock edge after an accepted request (`in_valid` high). `out_valid` mirrors `in_valid` one cycle later. Synchronous reset clears every output to zero. Capability vectors are 206 bits packed from MSB down as valid(1), type(3), cursor(64), base(64), end(64), perms(3), async(2), reg(5). The null capability is all zeros.
- R2: Move (op 0): with `same_idx` set it writes nothing. Otherwise the destination receives the source unchanged and the source is rewritten, to null unless its type is 1, in which case it keeps its value.
- R3: Cursor ops are increment by `opb` (op 1), increment by the sign-extended immediate (op 2) and set to `opb` (op 3). Each writes the destination as the source with only the cursor changed, using 64-bit wrap-around.
- R4: Shrink (op 5) sets base to `opa` and end to `opb`. The cursor is raised to `opa` if below it, otherwise lowered to `opb` if above it, otherwise kept.
- R5: Split (op 6) with `same_idx` set writes nothing. Otherwise the source becomes [base, `opb`) with cursor = base, and the destination becomes [`opb`, end) with cursor = `opb`. Both are written and neither is nulled.
- R6: Tighten (op 7) sets the destination perms to the immediate, or to 0 when the immediate exceeds 7. If the new perms are not a bitwise subset of the source perms, it faults with code 27.
- R7: Query (op 4) writes the integer result only. Selector (the immediate) 0..7 returns valid, type, cursor, base, end, perms, async, reg, zero-extended. A selector above 7 returns zero.
- R8: Delinearise (op 8) writes the destination as the source with type 1. Initialise (op 9) writes it with type 0 and cursor = base + `opb`.
- R9: Seal (op 10) writes the destination with type 4 and async 0. Make-revocation (op 11) writes the destination with type 2 and leaves the source unwritten.
- R10: Type codes are 0 linear, 1 non-linear, 2 revocation, 3 uninitialised, 4 sealed, 5 sealed-return. Every op except move and query faults with 25 on an invalid source. After that check, a type mismatch faults with 26. Ops 1, 2, 3, 5, 6 and 7 need type 0, 1 or 3; ops 8, 10 and 11 need type 0; op 9 needs type 3. A faulting op raises no write enable.
- R11: Ops 1, 2, 3, 5, 7, 9 and 10 use move-out semantics. With `same_idx` clear the source is written, as null unless its type is 1. With `same_idx` set the source is not written. Ops 8 and 11 never write the source.
- R12: The destination write and the integer write are never enabled in the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 4 | Operation code |
| same_idx | input | 1 | Source and destination indices are equal |
| src_cap | input | 206 | Source capability |
| opa | input | 64 | First integer operand |
| opb | input | 64 | Second integer operand |
| imm | input | 12 | Immediate / field selector |
| out_valid | output | 1 | Result present |
| dst_cap | output | 206 | Destination capability |
| dst_we | output | 1 | Destination write enable |
| src_cap_o | output | 206 | Rewritten source capability |
| src_we | output | 1 | Source write enable |
| int_res | output | 64 | Integer result of a query |
| int_we | output | 1 | Integer result write enable |
| fault | output | 6 | Fault code, 0 when none |

## Verification
Two effects can land in the same result cycle. One is the derivation of a new destination, such as a moved cursor, clamped bounds or a changed type. The other is the nulling of the source under move-out. Split adds a second case, where both halves are written together. The stimulus provokes these by pairing every deriving operation with linear, non-linear and uninitialised sources under both settings of `same_idx`. It then judges the destination, the rewritten source and both enables together against a model built from the requirements, so that a result with one correct half and the other half missing or stale is reported.

// File: rtl/cap_pkg.sv
package cap_pkg;
  parameter int ADDR_W  = 64;
  parameter int TYPE_W  = 3;
  parameter int PERM_W  = 3;
  parameter int ASYNC_W = 2;
  parameter int REG_W   = 5;
  parameter int IMM_W   = 12;
  parameter int OP_W    = 4;
  parameter int FAULT_W = 6;
  localparam int CAP_W  = 1 + TYPE_W + 3 * ADDR_W + PERM_W + ASYNC_W + REG_W;
  localparam int SEL_MAX = 7;
  localparam int PERM_MAX = (1 << PERM_W) - 1;

  typedef struct packed {
    logic               valid;
    logic [TYPE_W-1:0]  ctype;
    logic [ADDR_W-1:0]  cursor;
    logic [ADDR_W-1:0]  base;
    logic [ADDR_W-1:0]  bound_end;
    logic [PERM_W-1:0]  perms;
    logic [ASYNC_W-1:0] asyn;
    logic [REG_W-1:0]   reg_idx;
  } cap_t;

  typedef enum logic [OP_W-1:0] {
    OP_MOVE = 4'd0, OP_INCR = 4'd1, OP_INCI = 4'd2, OP_SETC = 4'd3,
    OP_QUERY = 4'd4, OP_SHRINK = 4'd5, OP_SPLIT = 4'd6, OP_TIGHTEN = 4'd7,
    OP_DELIN = 4'd8, OP_INIT = 4'd9, OP_SEAL = 4'd10, OP_MKREV = 4'd11
  } op_e;

  localparam logic [TYPE_W-1:0] T_LIN    = 3'd0;
  localparam logic [TYPE_W-1:0] T_NONLIN = 3'd1;
  localparam logic [TYPE_W-1:0] T_REVOKE = 3'd2;
  localparam logic [TYPE_W-1:0] T_UNINIT = 3'd3;
  localparam logic [TYPE_W-1:0] T_SEALED = 3'd4;

  localparam logic [FAULT_W-1:0] FLT_NONE    = 6'd0;
  localparam logic [FAULT_W-1:0] FLT_INVALID = 6'd25;
  localparam logic [FAULT_W-1:0] FLT_TYPE    = 6'd26;
  localparam logic [FAULT_W-1:0] FLT_PERM    = 6'd27;
endpackage

// File: rtl/cap_perm_le.sv
module cap_perm_le #(
  parameter int PW = 3
) (
  input  logic [PW-1:0] lo,
  input  logic [PW-1:0] hi,
  output logic          le
);
  logic [PW-1:0] extra;
  for (genvar g = 0; g < PW; g++) begin : g_bit
    assign extra[g] = lo[g] & ~hi[g];
  end
  assign le = ~|extra;
endmodule

// File: rtl/cap_field_sel.sv
module cap_field_sel
  import cap_pkg::*;
(
  input  cap_t              cap,
  input  logic [IMM_W-1:0]  sel,
  output logic [ADDR_W-1:0] value
);
  always_comb begin
    value = '0;
    if (sel <= IMM_W'(SEL_MAX)) begin
      case (sel[2:0])
        3'd0: value = ADDR_W'(cap.valid);
        3'd1: value = ADDR_W'(cap.ctype);
        3'd2: value = cap.cursor;
        3'd3: value = cap.base;
        3'd4: value = cap.bound_end;
        3'd5: value = ADDR_W'(cap.perms);
        3'd6: value = ADDR_W'(cap.asyn);
        default: value = ADDR_W'(cap.reg_idx);
      endcase
    end
  end
endmodule

// File: rtl/cap_op_core.sv
module cap_op_core
  import cap_pkg::*;
(
  input  op_e                op,
  input  logic               same_idx,
  input  cap_t               src,
  input  logic [ADDR_W-1:0]  opa,
  input  logic [ADDR_W-1:0]  opb,
  input  logic [IMM_W-1:0]   imm,
  output cap_t               dst_o,
  output cap_t               src_o,
  output logic               dst_we,
  output logic               src_we,
  output logic               int_we,
  output logic [ADDR_W-1:0]  int_o,
  output logic [FAULT_W-1:0] fault
);
  logic [PERM_W-1:0] new_perms;
  logic              perm_ok;
  logic [ADDR_W-1:0] field;
  logic [ADDR_W-1:0] imm_sx;
  cap_t              moved;
  logic              need_valid;
  logic              type_ok;
  logic              addr_type;

  assign new_perms = (imm > IMM_W'(PERM_MAX)) ? '0 : imm[PERM_W-1:0];
  assign imm_sx    = {{(ADDR_W-IMM_W){imm[IMM_W-1]}}, imm};
  assign moved     = (src.ctype == T_NONLIN) ? src : '0;
  assign addr_type = (src.ctype == T_LIN) || (src.ctype == T_NONLIN) ||
                     (src.ctype == T_UNINIT);

  cap_perm_le #(.PW(PERM_W)) u_perm (.lo(new_perms), .hi(src.perms), .le(perm_ok));
  cap_field_sel u_sel (.cap(src), .sel(imm), .value(field));

  always_comb begin
    need_valid = !(op == OP_MOVE || op == OP_QUERY);
    case (op)
      OP_INCR, OP_INCI, OP_SETC, OP_SHRINK, OP_SPLIT, OP_TIGHTEN: type_ok = addr_type;
      OP_DELIN, OP_SEAL, OP_MKREV: type_ok = (src.ctype == T_LIN);
      OP_INIT: type_ok = (src.ctype == T_UNINIT);
      default: type_ok = 1'b1;
    endcase
    if (need_valid && !src.valid)             fault = FLT_INVALID;
    else if (!type_ok)                        fault = FLT_TYPE;
    else if (op == OP_TIGHTEN && !perm_ok)    fault = FLT_PERM;
    else                                      fault = FLT_NONE;
  end

  always_comb begin
    dst_o  = src;
    src_o  = src;
    dst_we = 1'b0;
    src_we = 1'b0;
    int_we = 1'b0;
    int_o  = '0;
    if (fault == FLT_NONE) begin
      case (op)
        OP_MOVE: if (!same_idx) begin
          dst_we = 1'b1;
          src_we = 1'b1;
          src_o  = moved;
        end
        OP_QUERY: begin
          int_we = 1'b1;
          int_o  = field;
        end
        OP_SPLIT: if (!same_idx) begin
          dst_we          = 1'b1;
          src_we          = 1'b1;
          src_o.bound_end = opb;
          src_o.cursor    = src.base;
          dst_o.base      = opb;
          dst_o.cursor    = opb;
        end
        OP_DELIN: begin
          dst_we      = 1'b1;
          dst_o.ctype = T_NONLIN;
        end
        OP_MKREV: begin
          dst_we      = 1'b1;
          dst_o.ctype = T_REVOKE;
        end
        OP_INCR, OP_INCI, OP_SETC, OP_SHRINK, OP_TIGHTEN, OP_INIT, OP_SEAL: begin
          dst_we = 1'b1;
          src_we = !same_idx;
          src_o  = moved;
          case (op)
            OP_INCR: dst_o.cursor = src.cursor + opb;
            OP_INCI: dst_o.cursor = src.cursor + imm_sx;
            OP_SETC: dst_o.cursor = opb;
            OP_SHRINK: begin
              dst_o.base      = opa;
              dst_o.bound_end = opb;
              if (src.cursor < opa)      dst_o.cursor = opa;
              else if (src.cursor > opb) dst_o.cursor = opb;
              else                       dst_o.cursor = src.cursor;
            end
            OP_TIGHTEN: dst_o.perms = new_perms;
            OP_INIT: begin
              dst_o.ctype  = T_LIN;
              dst_o.cursor = src.base + opb;
            end
            default: begin
              dst_o.ctype = T_SEALED;
              dst_o.asyn  = '0;
            end
          endcase
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cap_derive_unit.sv
module cap_derive_unit
  import cap_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [OP_W-1:0]     op,
  input  logic                same_idx,
  input  logic [CAP_W-1:0]    src_cap,
  input  logic [ADDR_W-1:0]   opa,
  input  logic [ADDR_W-1:0]   opb,
  input  logic [IMM_W-1:0]    imm,
  output logic                out_valid,
  output logic [CAP_W-1:0]    dst_cap,
  output logic                dst_we,
  output logic [CAP_W-1:0]    src_cap_o,
  output logic                src_we,
  output logic [ADDR_W-1:0]   int_res,
  output logic                int_we,
  output logic [FAULT_W-1:0]  fault
);
  cap_t               src_in;
  cap_t               d_dst, d_src;
  logic               d_dwe, d_swe, d_iwe;
  logic [ADDR_W-1:0]  d_int;
  logic [FAULT_W-1:0] d_flt;

  assign src_in = cap_t'(src_cap);

  cap_op_core u_core (
    .op(op_e'(op)), .same_idx(same_idx), .src(src_in), .opa(opa), .opb(opb), .imm(imm),
    .dst_o(d_dst), .src_o(d_src), .dst_we(d_dwe), .src_we(d_swe), .int_we(d_iwe),
    .int_o(d_int), .fault(d_flt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dst_cap   <= '0;
      src_cap_o <= '0;
      dst_we    <= 1'b0;
      src_we    <= 1'b0;
      int_we    <= 1'b0;
      int_res   <= '0;
      fault     <= '0;
    end else begin
      out_valid <= in_valid;
      dst_we    <= in_valid & d_dwe;
      src_we    <= in_valid & d_swe;
      int_we    <= in_valid & d_iwe;
      fault     <= in_valid ? d_flt : '0;
      if (in_valid) begin
        dst_cap   <= d_dst;
        src_cap_o <= d_src;
        int_res   <= d_int;
      end
    end
  end

  cap_t dst_view, srco_view;
  assign dst_view  = cap_t'(dst_cap);
  assign srco_view = cap_t'(src_cap_o);

  AST_FAULT_BLOCKS_WRITES: assert property (@(posedge clk) disable iff (rst)
    (out_valid && fault != '0) |-> !(dst_we || src_we || int_we)); // R10

  AST_MOVE_NULLS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_MOVE && !same_idx && src_in.ctype != T_NONLIN)
    |=> (src_we && src_cap_o == '0)); // R2

  AST_SHRINK_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_SHRINK && src_in.valid && opa <= opb &&
     (src_in.ctype == T_LIN || src_in.ctype == T_NONLIN || src_in.ctype == T_UNINIT))
    |=> (dst_view.cursor >= dst_view.base && dst_view.cursor <= dst_view.bound_end)); // R4

  AST_TIGHTEN_SUBSET: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_TIGHTEN)
    |=> (!dst_we || (dst_view.perms & ~$past(src_in.perms)) == '0)); // R6

  AST_SPLIT_ADJACENT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_SPLIT)
    |=> (!dst_we || srco_view.bound_end == dst_view.base)); // R5

  AST_ONE_RESULT_KIND: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(int_we && dst_we)); // R12

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !(dst_we || src_we || int_we)); // R1
endmodule

// File: tb/cap_derive_unit_bench.sv
`timescale 1ns/1ps
module cap_derive_unit_bench;
  import cap_pkg::*;

  typedef struct {
    cap_t             dst;
    cap_t             srco;
    logic             dwe, swe, iwe;
    logic [63:0]      ires;
    logic [5:0]       flt;
  } res_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [3:0] op = '0;
  logic same_idx = 1'b0;
  logic [CAP_W-1:0] src_cap = '0;
  logic [63:0] opa = '0, opb = '0;
  logic [11:0] imm = '0;
  logic out_valid, dst_we, src_we, int_we;
  logic [CAP_W-1:0] dst_cap, src_cap_o;
  logic [63:0] int_res;
  logic [5:0] fault;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cap_derive_unit u_cap_derive_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .same_idx(same_idx),
    .src_cap(src_cap), .opa(opa), .opb(opb), .imm(imm), .out_valid(out_valid),
    .dst_cap(dst_cap), .dst_we(dst_we), .src_cap_o(src_cap_o), .src_we(src_we),
    .int_res(int_res), .int_we(int_we), .fault(fault)
  );

  function automatic string tag_of(int o, logic [5:0] f);
    if (f != 0) return "R10";
    case (o)
      0: return "R2";
      1, 2, 3: return "R3";
      4: return "R7";
      5: return "R4";
      6: return "R5";
      7: return "R6";
      8, 9: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic res_t model(int o, bit same, cap_t s, logic [63:0] a, logic [63:0] b,
                                 logic [11:0] im);
    res_t r;
    bit need_v, tok, mo;
    logic [2:0] np;
    cap_t nul;
    nul = '0;
    r.dst = s; r.srco = s; r.dwe = 0; r.swe = 0; r.iwe = 0; r.ires = '0; r.flt = 0;
    np = (im > 12'd7) ? 3'd0 : im[2:0];
    need_v = !(o == 0 || o == 4);
    if (o == 1 || o == 2 || o == 3 || o == 5 || o == 6 || o == 7) tok = (s.ctype == 0 || s.ctype == 1 || s.ctype == 3);
    else if (o == 8 || o == 10 || o == 11) tok = (s.ctype == 0);
    else if (o == 9) tok = (s.ctype == 3);
    else tok = 1;
    if (need_v && !s.valid) r.flt = 25;
    else if (!tok) r.flt = 26;
    else if (o == 7 && (np & ~s.perms) != 0) r.flt = 27;
    if (r.flt != 0) return r;
    mo = 0;
    case (o)
      0: if (!same) begin r.dwe = 1; r.swe = 1; r.srco = (s.ctype == 1) ? s : nul; end
      4: begin
        r.iwe = 1;
        case (im)
          0: r.ires = 64'(s.valid);
          1: r.ires = 64'(s.ctype);
          2: r.ires = s.cursor;
          3: r.ires = s.base;
          4: r.ires = s.bound_end;
          5: r.ires = 64'(s.perms);
          6: r.ires = 64'(s.asyn);
          7: r.ires = 64'(s.reg_idx);
          default: r.ires = 0;
        endcase
      end
      6: if (!same) begin
        r.dwe = 1; r.swe = 1;
        r.srco.bound_end = b; r.srco.cursor = s.base;
        r.dst.base = b; r.dst.cursor = b;
      end
      8: begin r.dwe = 1; r.dst.ctype = 1; end
      11: begin r.dwe = 1; r.dst.ctype = 2; end
      1: begin mo = 1; r.dst.cursor = s.cursor + b; end
      2: begin mo = 1; r.dst.cursor = s.cursor + {{52{im[11]}}, im}; end
      3: begin mo = 1; r.dst.cursor = b; end
      5: begin
        mo = 1; r.dst.base = a; r.dst.bound_end = b;
        r.dst.cursor = (s.cursor < a) ? a : ((s.cursor > b) ? b : s.cursor);
      end
      7: begin mo = 1; r.dst.perms = np; end
      9: begin mo = 1; r.dst.ctype = 0; r.dst.cursor = s.base + b; end
      default: begin mo = 1; r.dst.ctype = 4; r.dst.asyn = 0; end
    endcase
    if (mo) begin
      r.dwe = 1; r.swe = !same;
      r.srco = (s.ctype == 1) ? s : nul;
    end
    return r;
  endfunction

  task automatic fail_msg(string t, string what, logic [CAP_W-1:0] act, logic [CAP_W-1:0] exp);
    fails++;
    $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
  endtask

  task automatic run_op(int o, bit same, cap_t s, logic [63:0] a, logic [63:0] b,
                        logic [11:0] im, string extra_tag);
    res_t e;
    string t;
    bit bad;
    e = model(o, same, s, a, b, im);
    in_valid = 1; op = 4'(o); same_idx = same; src_cap = s; opa = a; opb = b; imm = im;
    @(negedge clk);
    in_valid = 0;
    t = {tag_of(o, e.flt), extra_tag};
    checks++;
    bad = 0;
    if (!out_valid) begin bad = 1; fail_msg("R1", "out_valid", CAP_W'(out_valid), CAP_W'(1)); end
    if (fault != e.flt) begin bad = 1; fail_msg(t, "fault", CAP_W'(fault), CAP_W'(e.flt)); end
    if ({dst_we, src_we, int_we} != {e.dwe, e.swe, e.iwe}) begin
      bad = 1; fail_msg(t, "enables", CAP_W'({dst_we, src_we, int_we}), CAP_W'({e.dwe, e.swe, e.iwe}));
    end
    if (dst_we && int_we) begin bad = 1; fail_msg("R12", "dst+int", 1, 0); end
    if (!bad && e.dwe && dst_cap != e.dst) fail_msg(t, "dst_cap", dst_cap, e.dst);
    if (!bad && e.swe && src_cap_o != e.srco) fail_msg({t, " R11"}, "src_cap_o", src_cap_o, e.srco);
    if (!bad && e.iwe && int_res != e.ires) fail_msg(t, "int_res", CAP_W'(int_res), CAP_W'(e.ires));
  endtask

  function automatic cap_t mk(logic v, logic [2:0] ty, logic [63:0] cur, logic [63:0] b,
                              logic [63:0] en, logic [2:0] p);
    cap_t c;
    c.valid = v; c.ctype = ty; c.cursor = cur; c.base = b; c.bound_end = en;
    c.perms = p; c.asyn = 2'd1; c.reg_idx = 5'd9;
    return c;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog expired actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    cap_t c;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid || dst_we || src_we || int_we || fault != 0 || dst_cap != '0 ||
        src_cap_o != '0 || int_res != '0)
      fail_msg("R1", "reset state", CAP_W'({out_valid, dst_we, src_we, int_we, fault}), '0);
    rst = 0;
    @(negedge clk);
    // R2: move, linear source nulled; non-linear kept; same index no-op
    c = mk(1, 0, 64'h100, 64'h80, 64'h200, 3'd7);
    run_op(0, 0, c, 0, 0, 0, "");
    run_op(0, 0, mk(1, 1, 64'h10, 0, 64'h40, 3'd5), 0, 0, 0, "");
    run_op(0, 1, c, 0, 0, 0, "");
    // R4: shrink clamps below and above
    run_op(5, 0, mk(1, 0, 64'h10, 0, 64'h1000, 3'd3), 64'h100, 64'h200, 0, "");
    run_op(5, 1, mk(1, 1, 64'h900, 0, 64'h1000, 3'd3), 64'h100, 64'h200, 0, "");
    // R5: split and same-index no-op
    run_op(6, 0, c, 0, 64'h150, 0, "");
    run_op(6, 1, c, 0, 64'h150, 0, "");
    // R6: tighten above 7 gives 0; non-subset faults 27
    run_op(7, 0, c, 0, 0, 12'd9, "");
    run_op(7, 0, mk(1, 0, 1, 0, 8, 3'd2), 0, 0, 12'd1, "");
    // R7: query selector edge cases
    run_op(4, 0, c, 0, 0, 12'd7, "");
    run_op(4, 0, c, 0, 0, 12'd8, "");
    run_op(4, 0, c, 0, 0, 12'd2, "");
    // R3: negative immediate increment
    run_op(2, 0, c, 0, 0, 12'hFFC, "");
    // R8/R9
    run_op(9, 0, mk(1, 3, 5, 64'h40, 64'h80, 3'd6), 0, 64'h20, 0, "");
    run_op(8, 0, c, 0, 0, 0, "");
    run_op(10, 1, c, 0, 0, 0, "");
    run_op(11, 0, c, 0, 0, 0, "");
    // R10: invalid source, wrong type
    run_op(1, 0, mk(0, 0, 1, 0, 8, 3'd7), 0, 4, 0, "");
    run_op(9, 0, c, 0, 4, 0, "");
    // random mix
    for (int i = 0; i < 600; i++) begin
      int o;
      logic [63:0] a, b;
      o = int'($urandom % 12);
      c.valid = ($urandom % 8) != 0;
      c.ctype = 3'($urandom % 6);
      c.cursor = 64'($urandom % 64); c.base = 64'($urandom % 64); c.bound_end = {$urandom, $urandom};
      c.perms = 3'($urandom); c.asyn = 2'($urandom); c.reg_idx = 5'($urandom);
      a = 64'($urandom % 64); b = 64'($urandom % 64);
      run_op(o, 1'($urandom), c, a, b, 12'($urandom % 24), " R11");
    end
    // R1: idle cycle drops out_valid and enables
    @(negedge clk);
    checks++;
    if (out_valid || dst_we || src_we || int_we)
      fail_msg("R1", "idle", CAP_W'({out_valid, dst_we, src_we, int_we}), '0);
    done = 1;
    finish_run();
  end
endmodule